// File: doc/BRIEF.md
# Ternary Word Balance Selector

This block prepares one line word for a ternary link so that the signal stays close to DC-neutral over time. A 20-bit payload is widened to 21 bits by putting a zero below its least significant bit. The result is split into seven 3-bit groups (tribits). The block then tries all eight ways of XOR-ing every tribit with a common 3-bit key. Each variant is scored by the DC bias it would add on the line, and the bias left over from earlier words is added to that score. The variant with the smallest net bias wins.

A start strobe hands the block a payload and one "same" flag per tribit. A set flag marks a tribit that the later mapping stage replaces by the repeat symbol, so that tribit adds nothing to the bias. The block scores one key per clock over eight cycles. It then raises a one-cycle done strobe and presents three results:
- the winning key, which the serialiser sends as an eighth tribit;
- the seven rotated tribits;
- the updated running disparity, which the next word's search starts from.

Top module: `tbal_select`

## Requirements
- R1: The 21-bit extended word is `{payload, 1'b0}`. Tribit i is bits [3i+2:3i] of that word, so tribit 0 holds payload[1:0] above a zero bit.
- R2: With done high, `trib_out` equals the extended word with every tribit XOR-ed with `rot`.
- R3: Tribit weights are: 010 gives +2; 100 and 101 give +1; 110 and 111 give 0; 000 and 001 give -1; 011 gives -2. A key's word weight is the sum of the weights of the seven rotated tribits.
- R4: A tribit whose `same` bit (bit i for tribit i) is set adds weight 0 for every key. With all seven flags set, every key ties, so key 0 is chosen and the running disparity does not change.
- R5: The chosen key k minimises |running disparity + word weight of k|. On equal magnitude the lower k wins.
- R6: `rd_out` is a signed 6-bit value that takes the chosen net bias, clamped to [-32, +31], at the edge that raises done. It holds at all other times. It starts from 0 after reset.
- R7: `done` is a single-cycle pulse that comes up 8 cycles after the clock edge that accepts `start`. While a search is running, `start` is ignored, including on the edge that ends the search. It is accepted again on the next edge after that.
- R8: During and just after reset, `done`, `rot`, `trib_out` and `rd_out` are all zero.
- R9: `rot` and `trib_out` change only at the edge that raises done, and hold between results.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a search on this payload when idle |
| payload | input | 20 | Data bits of the word |
| same | input | 7 | Per-tribit repeat-symbol flags, bit i for tribit i |
| done | output | 1 | One-cycle strobe: results valid |
| rot | output | 3 | Chosen XOR key, sent as the eighth tribit |
| trib_out | output | 21 | Rotated seven tribits of the chosen variant |
| rd_out | output | 6 | Running disparity after the last word, signed |

## Verification
All four results of a word appear together, 8 cycles after the edge that took its start strobe. They then hold until the next such pulse. The bench model counts edges from each accepted start, so it predicts the exact cycle of every done pulse. It also models start being ignored during a search and on the search's final edge. It compares done, rot, trib_out and rd_out on every falling edge, half a cycle after the registers that drive them update. Between pulses it requires each output to equal the value it last predicted.

// File: rtl/tbal_pkg.sv
package tbal_pkg;

  localparam int TRIB_W = 3;

  // DC weight of one tribit after rotation (range -2..+2)
  function automatic logic signed [2:0] trib_weight(input logic [TRIB_W-1:0] t);
    logic signed [2:0] w;
    unique case (t)
      3'b000, 3'b001: w = -3'sd1;
      3'b010:         w =  3'sd2;
      3'b011:         w = -3'sd2;
      3'b100, 3'b101: w =  3'sd1;
      default:        w =  3'sd0;
    endcase
    return w;
  endfunction

endpackage

// File: rtl/tbal_weigh.sv
module tbal_weigh #(
  parameter int NTRIB = 7,
  parameter int SUM_W = 5,
  localparam int TW   = tbal_pkg::TRIB_W
) (
  input  logic [NTRIB*TW-1:0]     word_i,
  input  logic [NTRIB-1:0]        same_i,
  input  logic [TW-1:0]           key_i,
  output logic signed [SUM_W-1:0] sum_o
);

  logic signed [SUM_W-1:0] term [NTRIB];

  for (genvar g = 0; g < NTRIB; g++) begin : g_term
    logic [TW-1:0] rotated;
    assign rotated = word_i[g*TW +: TW] ^ key_i;
    // a repeated tribit is sent as the neutral symbol
    assign term[g] = same_i[g] ? '0 : SUM_W'(tbal_pkg::trib_weight(rotated));
  end

  always_comb begin
    sum_o = '0;
    for (int i = 0; i < NTRIB; i++) sum_o = sum_o + term[i];
  end

endmodule

// File: rtl/tbal_search.sv
module tbal_search #(
  parameter int KEY_W  = 3,
  parameter int BIAS_W = 7,
  localparam int NCAND = 1 << KEY_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start_i,
  input  logic signed [BIAS_W-1:0] bias_i,
  output logic                     accept_o,
  output logic                     busy_o,
  output logic                     last_o,
  output logic [KEY_W-1:0]         key_o,
  output logic [KEY_W-1:0]         win_key_o,
  output logic signed [BIAS_W-1:0] win_bias_o
);

  function automatic logic [BIAS_W-1:0] magnitude(input logic signed [BIAS_W-1:0] v);
    return (v < 0) ? BIAS_W'(-v) : BIAS_W'(v);
  endfunction

  logic                     busy_q;
  logic [KEY_W-1:0]         key_q;
  logic [KEY_W-1:0]         best_key_q;
  logic signed [BIAS_W-1:0] best_bias_q;
  logic                     take;

  assign accept_o = start_i && !busy_q;
  assign busy_o   = busy_q;
  assign key_o    = key_q;
  assign last_o   = busy_q && (key_q == KEY_W'(NCAND - 1));

  // first key always seeds the best; later ones must be strictly better
  assign take       = (key_q == '0) || (magnitude(bias_i) < magnitude(best_bias_q));
  assign win_key_o  = take ? key_q  : best_key_q;
  assign win_bias_o = take ? bias_i : best_bias_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q      <= 1'b0;
      key_q       <= '0;
      best_key_q  <= '0;
      best_bias_q <= '0;
    end else if (accept_o) begin
      busy_q <= 1'b1;
      key_q  <= '0;
    end else if (busy_q) begin
      best_key_q  <= win_key_o;
      best_bias_q <= win_bias_o;
      key_q       <= key_q + 1'b1;
      if (last_o) busy_q <= 1'b0;
    end
  end

endmodule

// File: rtl/tbal_select.sv
module tbal_select #(
  parameter int PAY_W  = 20,
  parameter int RD_W   = 6,
  localparam int TW     = tbal_pkg::TRIB_W,
  localparam int NTRIB  = (PAY_W + TW - 1) / TW,
  localparam int EXT_W  = NTRIB * TW,
  localparam int PAD_W  = EXT_W - PAY_W,
  localparam int NCAND  = 1 << TW,
  localparam int SUM_W  = $clog2(2 * NTRIB + 1) + 1,
  localparam int BIAS_W = ((RD_W > SUM_W) ? RD_W : SUM_W) + 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [PAY_W-1:0]       payload,
  input  logic [NTRIB-1:0]       same,
  output logic                   done,
  output logic [TW-1:0]          rot,
  output logic [EXT_W-1:0]       trib_out,
  output logic signed [RD_W-1:0] rd_out
);

  localparam logic signed [BIAS_W-1:0] RD_HI = BIAS_W'((2 ** (RD_W - 1)) - 1);
  localparam logic signed [BIAS_W-1:0] RD_LO = BIAS_W'(-(2 ** (RD_W - 1)));

  function automatic logic signed [RD_W-1:0] clamp_rd(input logic signed [BIAS_W-1:0] b);
    if (b > RD_HI) return RD_W'(RD_HI);
    if (b < RD_LO) return RD_W'(RD_LO);
    return RD_W'(b);
  endfunction

  // named internal events (also observed by the bound checker)
  logic                     accept;
  logic                     busy;
  logic                     last_eval;
  logic [TW-1:0]            cur_key;
  logic [TW-1:0]            win_key;
  logic signed [SUM_W-1:0]  cur_sum;
  logic signed [BIAS_W-1:0] cur_bias;
  logic signed [BIAS_W-1:0] win_bias;

  logic [EXT_W-1:0]         word_q;
  logic [NTRIB-1:0]         same_q;
  logic signed [RD_W-1:0]   rd_q;
  logic [EXT_W-1:0]         key_rep;

  assign key_rep  = {NTRIB{win_key}};
  assign cur_bias = BIAS_W'(rd_q) + BIAS_W'(cur_sum);
  assign rd_out   = rd_q;

  tbal_weigh #(.NTRIB(NTRIB), .SUM_W(SUM_W)) u_weigh (
    .word_i (word_q),
    .same_i (same_q),
    .key_i  (cur_key),
    .sum_o  (cur_sum)
  );

  tbal_search #(.KEY_W(TW), .BIAS_W(BIAS_W)) u_search (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start),
    .bias_i     (cur_bias),
    .accept_o   (accept),
    .busy_o     (busy),
    .last_o     (last_eval),
    .key_o      (cur_key),
    .win_key_o  (win_key),
    .win_bias_o (win_bias)
  );

  // capture the word and its flags once, hold them for the whole search
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_q <= '0;
      same_q <= '0;
    end else if (accept) begin
      word_q <= EXT_W'(payload) << PAD_W;
      same_q <= same;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done     <= 1'b0;
      rot      <= '0;
      trib_out <= '0;
      rd_q     <= '0;
    end else begin
      done <= last_eval;
      if (last_eval) begin
        rot      <= win_key;
        trib_out <= word_q ^ key_rep;
        rd_q     <= clamp_rd(win_bias);
      end
    end
  end

endmodule

// File: rtl/tbal_checker.sv
module tbal_checker #(
  parameter int NTRIB = 7,
  parameter int NCAND = 8,
  parameter int TW    = 3,
  parameter int EXT_W = 21,
  parameter int RD_W  = 6
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   accept,
  input logic                   busy,
  input logic                   done,
  input logic [TW-1:0]          rot,
  input logic [EXT_W-1:0]       trib_out,
  input logic signed [RD_W-1:0] rd_out
);

  localparam int CNT_W = $clog2(NCAND + 1) + 1;

  logic             pend;
  logic [CNT_W-1:0] since;

  // edges elapsed since the last accepted start
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend  <= 1'b0;
      since <= '0;
    end else if (accept) begin
      pend  <= 1'b1;
      since <= '0;
    end else if (done) begin
      pend <= 1'b0;
    end else if (pend) begin
      since <= since + 1'b1;
    end
  end

  assert_done_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (pend && since == CNT_W'(NCAND)));

  assert_done_due_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && since == CNT_W'(NCAND)) |-> done);

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_busy_after_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);

  assert_rd_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(rd_out));

  assert_rd_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((int'(rd_out) - int'($past(rd_out)) <= 2 * NTRIB) &&
              (int'(rd_out) - int'($past(rd_out)) >= -2 * NTRIB)));

  assert_out_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(rot) && $stable(trib_out)));

endmodule

bind tbal_select tbal_checker #(
  .NTRIB(NTRIB), .NCAND(NCAND), .TW(TW), .EXT_W(EXT_W), .RD_W(RD_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .accept   (accept),
  .busy     (busy),
  .done     (done),
  .rot      (rot),
  .trib_out (trib_out),
  .rd_out   (rd_out)
);

// File: tb/sim_tbal_select.sv
module sim_tbal_select;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [19:0] payload = '0;
  logic [6:0]  same = '0;
  logic        done;
  logic [2:0]  rot;
  logic [20:0] trib_out;
  logic signed [5:0] rd_out;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  tbal_select u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .payload(payload), .same(same),
    .done(done), .rot(rot), .trib_out(trib_out), .rd_out(rd_out)
  );

  // ---------------- reference model ----------------
  function automatic int ref_w(input bit [2:0] t);
    if (t == 3'd2) return 2;
    if (t == 3'd3) return -2;
    if (t == 3'd4 || t == 3'd5) return 1;
    if (t == 3'd0 || t == 3'd1) return -1;
    return 0;
  endfunction

  function automatic int iabs(input int v);
    return (v < 0) ? -v : v;
  endfunction

  task automatic ref_pick(input bit [19:0] pay, input bit [6:0] sm, input int rd,
                          output bit [2:0] k_o, output bit [20:0] t_o, output int rd_o);
    bit [20:0] ext;
    int best_b;
    int best_k;
    ext = {pay, 1'b0};                                   // R1 extension
    best_k = -1;
    best_b = 0;
    for (int k = 0; k < 8; k++) begin
      int s = 0;
      for (int i = 0; i < 7; i++) begin
        bit [2:0] t;
        t = ext[3*i +: 3] ^ 3'(k);
        if (!sm[i]) s += ref_w(t);                       // R3, R4
      end
      if (best_k < 0 || iabs(rd + s) < iabs(best_b)) begin   // R5
        best_k = k;
        best_b = rd + s;
      end
    end
    k_o = 3'(best_k);
    t_o = ext ^ {7{3'(best_k)}};
    rd_o = (best_b > 31) ? 31 : ((best_b < -32) ? -32 : best_b);   // R6
  endtask

  int        m_cnt = 0;
  bit        m_done = 0;
  bit [2:0]  m_rot = 0, p_rot;
  bit [20:0] m_trib = 0, p_trib;
  int        m_rd = 0, p_rd;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_done = 0; m_rot = 0; m_trib = 0; m_rd = 0;
    end else begin
      m_done = 0;
      if (m_cnt == 0) begin
        if (start) begin
          ref_pick(payload, same, m_rd, p_rot, p_trib, p_rd);
          m_cnt = 8;
        end
      end else begin
        m_cnt--;
        if (m_cnt == 0) begin
          m_done = 1; m_rot = p_rot; m_trib = p_trib; m_rd = p_rd;
        end
      end
    end
  end

  task automatic check(input bit ok, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!finished) begin
      string tag_o;
      tag_o = !rst_n ? "R8" : (m_done ? "" : "R9 hold");
      check(done == m_done, !rst_n ? "R8 done" : "R7 done", done, m_done);
      check(rot == m_rot, {tag_o, " R3 R4 R5 rot"}, rot, m_rot);
      check(trib_out == m_trib, {tag_o, " R1 R2 trib_out"}, trib_out, m_trib);
      check(int'(rd_out) == m_rd, !rst_n ? "R8 rd_out" : "R6 rd_out", rd_out, m_rd);
    end
  end

  // ---------------- stimulus ----------------
  task automatic send(input bit [19:0] p, input bit [6:0] s);
    @(negedge clk);
    start = 1'b1; payload = p; same = s;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done();
    while (done !== 1'b1) @(negedge clk);
  endtask

  task automatic finish_run();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 20000);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // all-zero word: every tribit becomes k; key 6 gives weight 0 (R3)
    send(20'h0, 7'h0);
    wait_done();
    check(rot == 3'd6, "R3 zero word key", rot, 6);
    check(rd_out == 0, "R3 zero word rd", rd_out, 0);
    @(negedge clk);

    // all flags set: all keys tie, key 0, rd unchanged (R4, R5)
    send(20'hFFFFF, 7'h7F);
    wait_done();
    check(rot == 3'd0, "R4 all-same key", rot, 0);
    @(negedge clk);

    // start pulses during a search must be ignored (R7)
    send(20'hA5A5A, 7'h00);
    repeat (2) @(negedge clk);
    send(20'h12345, 7'h11);
    wait_done();
    repeat (4) @(negedge clk);

    // start held high: back-to-back words, gap on the final search edge (R7)
    @(negedge clk);
    start = 1'b1; payload = 20'hFFFFF; same = 7'h00;
    repeat (30) begin
      @(negedge clk);
      payload = 20'($urandom);
      same = 7'($urandom) & 7'h24;
    end
    start = 1'b0;
    repeat (12) @(negedge clk);

    // biased payloads to drive the running disparity around (R5, R6)
    for (int n = 0; n < 40; n++) begin
      bit [19:0] p;
      p = (n % 3 == 0) ? 20'h92492 : 20'($urandom);
      send(p, (n % 4 == 0) ? 7'($urandom) : 7'h00);
      repeat (9 + (n % 3)) @(negedge clk);
    end

    repeat (5) @(negedge clk);
    finish_run();
  end

endmodule